// File: doc/BRIEF.md
# Priority Packet Sorting Switch Node

This block is a synchronous two-input, two-output switching node that works in fixed packet slots. A slot is marked by a one-cycle strobe. At that clock edge the node takes up to two packets, one on input X and one on input Y. Each packet carries a one-bit type, a priority and a payload. Output port A serves only type-A packets and port B serves only type-B packets. In each slot a port sends the most urgent packet of its type. The contest covers both the new arrivals and the packets the node already holds.

A packet that loses its contest is not lost. It is kept in a small store that belongs to its type, and it competes again in every later slot. The store therefore behaves as a priority queue, not as a first-in first-out buffer. Each store has a full flag. When a store cannot take another loser, the least urgent packet of that type is discarded and a one-cycle drop pulse is raised for that type.

Top module: `psort_node`

## Requirements
- R1: State and outputs change only at a clock edge where `slotStb` is high. While `slotStb` is low, the packet inputs are ignored and every output except the drop pulses holds its value.
- R2: Type bit 0 means type A and type bit 1 means type B. A type-A packet leaves only on port A (`aValid`/`aPrio`/`aData`) and a type-B packet leaves only on port B.
- R3: In each slot, each port sends the packet of its type with the numerically largest priority. The candidates are the valid arrivals of that type and the packets of that type held in the store.
- R4: Ties at equal priority are settled in this order: a stored packet beats an arrival, and input X beats input Y.
- R5: Each type has a store of 4 entries. Every candidate that does not leave in a slot is kept in its type's store. `aFull`/`bFull` are high exactly when that type's store holds 4 packets.
- R6: If the losers of a slot do not fit in their type's store, one packet is discarded. It is the least urgent among the store and the losers; at equal priority the arrival from Y goes first, then the arrival from X, then stored packets. The type's drop output (`aDrop`/`bDrop`) is high for exactly the one cycle after that slot.
- R7: A port that has no packet of its type available in a slot drives its valid output low for that slot.
- R8: A synchronous active-high reset empties both stores and clears both valid outputs, both full flags and both drop pulses.
- R9: Port outputs are registered. They show the result of a slot from the cycle after the strobe edge and hold it until the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slotStb | input | 1 | Marks the clock edge that ends a packet slot |
| xValid | input | 1 | Input X carries a packet |
| xType | input | 1 | Type of X: 0 = A, 1 = B |
| xPrio | input | PRIO_W | Priority of X; larger is more urgent |
| xData | input | DATA_W | Payload of X |
| yValid | input | 1 | Input Y carries a packet |
| yType | input | 1 | Type of Y: 0 = A, 1 = B |
| yPrio | input | PRIO_W | Priority of Y |
| yData | input | DATA_W | Payload of Y |
| aValid | output | 1 | Port A sends a packet this slot |
| aPrio | output | PRIO_W | Priority of the packet on port A |
| aData | output | DATA_W | Payload on port A |
| bValid | output | 1 | Port B sends a packet this slot |
| bPrio | output | PRIO_W | Priority of the packet on port B |
| bData | output | DATA_W | Payload on port B |
| aFull | output | 1 | Type-A store holds 4 packets |
| bFull | output | 1 | Type-B store holds 4 packets |
| aDrop | output | 1 | One-cycle pulse: a type-A packet was discarded |
| bDrop | output | 1 | One-cycle pulse: a type-B packet was discarded |

## Verification
The bench builds the node with its default 4-bit priority and 8-bit payload, so every priority value and tie can be written by hand. With a store depth of 4, a single type fills after a few slots of same-type pairs. That puts both overflow cases within a dozen slots: discarding an arrival and discarding a stored packet. Draining the store afterwards, one slot at a time, shows at the output ports which packets were kept and in what priority order.

// File: rtl/psort_pkg.sv
package psort_pkg;
  // entries per type store; candidates are the store plus the two inputs
  localparam int unsigned SORT_DEPTH = 4;
  localparam int unsigned SORT_CAND  = SORT_DEPTH + 2;
  localparam int unsigned X_IDX      = SORT_DEPTH;
  localparam int unsigned Y_IDX      = SORT_DEPTH + 1;
  localparam int unsigned NUM_TYPES  = 2;

  // strobes from the selection control to one lane's datapath
  typedef struct packed {
    logic                  slot;
    logic                  drop;
    logic [SORT_CAND-1:0]  outSel;
    logic [SORT_DEPTH-1:0] clrSlot;
    logic [SORT_DEPTH-1:0] ldX;
    logic [SORT_DEPTH-1:0] ldY;
  } sortStrobe_t;
endpackage

// File: rtl/psort_ctrl.sv
module psort_ctrl
  import psort_pkg::*;
#(
  parameter int unsigned PRIO_W = 4
) (
  input  logic                              slotStb,
  input  logic [SORT_DEPTH-1:0]             storeValid,
  input  logic [SORT_DEPTH-1:0][PRIO_W-1:0] storePrio,
  input  logic                              xHit,
  input  logic [PRIO_W-1:0]                 xPrio,
  input  logic                              yHit,
  input  logic [PRIO_W-1:0]                 yPrio,
  output sortStrobe_t                       strb
);
  logic [SORT_CAND-1:0]             candV;
  logic [SORT_CAND-1:0][PRIO_W-1:0] candP;
  logic [SORT_CAND-1:0]             winMask, dropMask, remMask, keepMask;
  logic [SORT_DEPTH-1:0]            freeSlot, ldXMask, ldYMask;
  logic                             winFound, dropFound, dropNeed;
  logic [PRIO_W-1:0]                bestP, minP;
  int                               winIdx, dropIdx, remCnt;
  logic                             xPlaced, yPlaced;

  always_comb begin
    candV = {yHit, xHit, storeValid};
    candP = {yPrio, xPrio, storePrio};

    // maximum search: strict compare keeps the earliest (stored, then X, then Y)
    winFound = 1'b0;
    winIdx   = 0;
    bestP    = '0;
    for (int i = 0; i < int'(SORT_CAND); i++) begin
      if (candV[i] && (!winFound || candP[i] > bestP)) begin
        winFound = 1'b1;
        winIdx   = i;
        bestP    = candP[i];
      end
    end
    for (int i = 0; i < int'(SORT_CAND); i++) winMask[i] = winFound && (i == winIdx);
    remMask = candV & ~winMask;
    remCnt  = $countones(remMask);
    dropNeed = remCnt > int'(SORT_DEPTH);

    // minimum search: non-strict compare keeps the latest (least preferred)
    dropFound = 1'b0;
    dropIdx   = 0;
    minP      = '0;
    for (int i = 0; i < int'(SORT_CAND); i++) begin
      if (remMask[i] && (!dropFound || candP[i] <= minP)) begin
        dropFound = 1'b1;
        dropIdx   = i;
        minP      = candP[i];
      end
    end
    for (int i = 0; i < int'(SORT_CAND); i++) dropMask[i] = dropNeed && (i == dropIdx);
    keepMask = remMask & ~dropMask;

    // slot allocation for kept arrivals: first free slot to X, next to Y
    freeSlot = ~keepMask[SORT_DEPTH-1:0];
    ldXMask  = '0;
    ldYMask  = '0;
    xPlaced  = !keepMask[X_IDX];
    yPlaced  = !keepMask[Y_IDX];
    for (int j = 0; j < int'(SORT_DEPTH); j++) begin
      if (freeSlot[j]) begin
        if (!xPlaced) begin
          ldXMask[j] = 1'b1;
          xPlaced    = 1'b1;
        end else if (!yPlaced) begin
          ldYMask[j] = 1'b1;
          yPlaced    = 1'b1;
        end
      end
    end

    strb.slot    = slotStb;
    strb.drop    = slotStb && dropNeed;
    strb.outSel  = slotStb ? winMask : '0;
    strb.clrSlot = slotStb ? (winMask[SORT_DEPTH-1:0] | dropMask[SORT_DEPTH-1:0]) : '0;
    strb.ldX     = slotStb ? ldXMask : '0;
    strb.ldY     = slotStb ? ldYMask : '0;
  end
endmodule

// File: rtl/psort_path.sv
module psort_path
  import psort_pkg::*;
#(
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  sortStrobe_t                       strb,
  input  logic [PRIO_W-1:0]                 xPrio,
  input  logic [DATA_W-1:0]                 xData,
  input  logic [PRIO_W-1:0]                 yPrio,
  input  logic [DATA_W-1:0]                 yData,
  output logic [SORT_DEPTH-1:0]             storeValid,
  output logic [SORT_DEPTH-1:0][PRIO_W-1:0] storePrio,
  output logic                              outValid,
  output logic [PRIO_W-1:0]                 outPrio,
  output logic [DATA_W-1:0]                 outData,
  output logic                              full,
  output logic                              drop
);
  logic [SORT_DEPTH-1:0][DATA_W-1:0] storeData;
  logic [SORT_CAND-1:0][PRIO_W-1:0]  candP;
  logic [SORT_CAND-1:0][DATA_W-1:0]  candD;
  logic [PRIO_W-1:0]                 selP;
  logic [DATA_W-1:0]                 selD;

  always_comb begin
    candP = {yPrio, xPrio, storePrio};
    candD = {yData, xData, storeData};
    selP  = '0;
    selD  = '0;
    for (int i = 0; i < int'(SORT_CAND); i++) begin
      if (strb.outSel[i]) begin
        selP = candP[i];
        selD = candD[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      storeValid <= '0;
      outValid   <= 1'b0;
      outPrio    <= '0;
      outData    <= '0;
      drop       <= 1'b0;
    end else begin
      drop <= strb.drop;
      if (strb.slot) begin
        outValid <= |strb.outSel;
        if (|strb.outSel) begin
          outPrio <= selP;
          outData <= selD;
        end
      end
      for (int j = 0; j < int'(SORT_DEPTH); j++) begin
        if (strb.ldX[j]) begin
          storeValid[j] <= 1'b1;
          storePrio[j]  <= xPrio;
          storeData[j]  <= xData;
        end else if (strb.ldY[j]) begin
          storeValid[j] <= 1'b1;
          storePrio[j]  <= yPrio;
          storeData[j]  <= yData;
        end else if (strb.clrSlot[j]) begin
          storeValid[j] <= 1'b0;
        end
      end
    end
  end

  assign full = &storeValid;
endmodule

// File: rtl/psort_node.sv
module psort_node
  import psort_pkg::*;
#(
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slotStb,
  input  logic              xValid,
  input  logic              xType,
  input  logic [PRIO_W-1:0] xPrio,
  input  logic [DATA_W-1:0] xData,
  input  logic              yValid,
  input  logic              yType,
  input  logic [PRIO_W-1:0] yPrio,
  input  logic [DATA_W-1:0] yData,
  output logic              aValid,
  output logic [PRIO_W-1:0] aPrio,
  output logic [DATA_W-1:0] aData,
  output logic              bValid,
  output logic [PRIO_W-1:0] bPrio,
  output logic [DATA_W-1:0] bData,
  output logic              aFull,
  output logic              bFull,
  output logic              aDrop,
  output logic              bDrop
);
  logic [NUM_TYPES-1:0]             laneValid, laneFull, laneDrop;
  logic [NUM_TYPES-1:0][PRIO_W-1:0] lanePrio;
  logic [NUM_TYPES-1:0][DATA_W-1:0] laneData;

  for (genvar t = 0; t < int'(NUM_TYPES); t++) begin : g_lane
    localparam logic TYPE_BIT = (t != 0);
    sortStrobe_t                       strb;
    logic [SORT_DEPTH-1:0]             storeValid;
    logic [SORT_DEPTH-1:0][PRIO_W-1:0] storePrio;
    logic                              xHit, yHit;

    assign xHit = xValid && (xType == TYPE_BIT);
    assign yHit = yValid && (yType == TYPE_BIT);

    psort_ctrl #(.PRIO_W(PRIO_W)) u_ctrl (
      .slotStb    (slotStb),
      .storeValid (storeValid),
      .storePrio  (storePrio),
      .xHit       (xHit),
      .xPrio      (xPrio),
      .yHit       (yHit),
      .yPrio      (yPrio),
      .strb       (strb)
    );

    psort_path #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_path (
      .clk        (clk),
      .rst        (rst),
      .strb       (strb),
      .xPrio      (xPrio),
      .xData      (xData),
      .yPrio      (yPrio),
      .yData      (yData),
      .storeValid (storeValid),
      .storePrio  (storePrio),
      .outValid   (laneValid[t]),
      .outPrio    (lanePrio[t]),
      .outData    (laneData[t]),
      .full       (laneFull[t]),
      .drop       (laneDrop[t])
    );
  end

  assign aValid = laneValid[0];
  assign aPrio  = lanePrio[0];
  assign aData  = laneData[0];
  assign aFull  = laneFull[0];
  assign aDrop  = laneDrop[0];
  assign bValid = laneValid[1];
  assign bPrio  = lanePrio[1];
  assign bData  = laneData[1];
  assign bFull  = laneFull[1];
  assign bDrop  = laneDrop[1];
endmodule

// File: rtl/psort_node_chk.sv
module psort_node_chk #(
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              slotStb,
  input logic              xValid,
  input logic              xType,
  input logic [PRIO_W-1:0] xPrio,
  input logic [DATA_W-1:0] xData,
  input logic              yValid,
  input logic              yType,
  input logic [PRIO_W-1:0] yPrio,
  input logic [DATA_W-1:0] yData,
  input logic              aValid,
  input logic [PRIO_W-1:0] aPrio,
  input logic [DATA_W-1:0] aData,
  input logic              bValid,
  input logic [PRIO_W-1:0] bPrio,
  input logic [DATA_W-1:0] bData,
  input logic              aFull,
  input logic              bFull,
  input logic              aDrop,
  input logic              bDrop
);
  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!aValid && !bValid && !aFull && !bFull && !aDrop && !bDrop));

  // R1
  idle_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    !slotStb |=> ($stable(aValid) && $stable(aPrio) && $stable(aData) && $stable(aFull)));

  // R1
  idle_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    !slotStb |=> ($stable(bValid) && $stable(bPrio) && $stable(bData) && $stable(bFull)));

  // R3
  a_beats_x_chk: assert property (@(posedge clk) disable iff (rst)
    (slotStb && xValid && !xType) |=> (aValid && aPrio >= $past(xPrio)));

  // R3
  a_beats_y_chk: assert property (@(posedge clk) disable iff (rst)
    (slotStb && yValid && !yType) |=> (aValid && aPrio >= $past(yPrio)));

  // R3
  b_beats_x_chk: assert property (@(posedge clk) disable iff (rst)
    (slotStb && xValid && xType) |=> (bValid && bPrio >= $past(xPrio)));

  // R3
  b_beats_y_chk: assert property (@(posedge clk) disable iff (rst)
    (slotStb && yValid && yType) |=> (bValid && bPrio >= $past(yPrio)));

  // R6
  a_drop_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    (slotStb && !aFull) |=> !aDrop);

  // R6
  b_drop_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    (slotStb && !bFull) |=> !bDrop);

  // R6
  drop_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !slotStb |=> (!aDrop && !bDrop));

  // R2
  type_mix_chk: assert property (@(posedge clk) disable iff (rst)
    (slotStb && xValid && yValid && xType != yType) |=> (aValid && bValid));
endmodule

bind psort_node psort_node_chk #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_psort_node.sv
module sim_psort_node;
  localparam int PW = 4;
  localparam int DW = 8;

  typedef struct packed {
    logic xv; logic xt; logic [3:0] xp; logic [7:0] xd;
    logic yv; logic yt; logic [3:0] yp; logic [7:0] yd;
    logic av; logic [3:0] ap; logic [7:0] ad;
    logic bv; logic [3:0] bp; logic [7:0] bd;
    logic af; logic da; logic db;
  } vec_t;

  // inputs: xv xt xp xd  yv yt yp yd | expected: av ap ad  bv bp bd  af da db
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1,0,5,8'h01, 1,1,3,8'h02, 1,5,8'h01, 1,3,8'h02, 0,0,0}, // mixed types
    '{1,0,2,8'h03, 1,0,7,8'h04, 1,7,8'h04, 0,0,8'h00, 0,0,0}, // Y wins, X stored
    '{0,0,0,8'h00, 0,0,0,8'h00, 1,2,8'h03, 0,0,8'h00, 0,0,0}, // store drains
    '{1,0,4,8'h05, 1,0,4,8'h06, 1,4,8'h05, 0,0,8'h00, 0,0,0}, // tie: X over Y
    '{1,0,4,8'h07, 0,0,0,8'h00, 1,4,8'h06, 0,0,8'h00, 0,0,0}, // tie: stored over X
    '{1,0,1,8'h08, 1,0,3,8'h09, 1,4,8'h07, 0,0,8'h00, 0,0,0},
    '{1,0,6,8'h0A, 1,0,2,8'h0B, 1,6,8'h0A, 0,0,8'h00, 0,0,0},
    '{1,0,0,8'h0C, 1,0,5,8'h0D, 1,5,8'h0D, 0,0,8'h00, 1,0,0}, // store full
    '{1,0,9,8'h0E, 1,0,0,8'h0F, 1,9,8'h0E, 0,0,8'h00, 1,1,0}, // Y arrival dropped
    '{1,0,6,8'h10, 1,0,5,8'h12, 1,6,8'h10, 0,0,8'h00, 1,1,0}, // stored p0 dropped
    '{0,0,0,8'h00, 1,1,8,8'h11, 1,5,8'h12, 1,8,8'h11, 0,0,0},
    '{0,0,0,8'h00, 0,0,0,8'h00, 1,3,8'h09, 0,0,8'h00, 0,0,0},
    '{1,1,2,8'h13, 1,1,9,8'h14, 1,2,8'h0B, 1,9,8'h14, 0,0,0}, // type B pair
    '{0,0,0,8'h00, 0,0,0,8'h00, 1,1,8'h08, 1,2,8'h13, 0,0,0},
    '{0,0,0,8'h00, 0,0,0,8'h00, 0,0,8'h00, 0,0,8'h00, 0,0,0}  // both empty
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slotStb = 1'b0;
  logic          xValid = 1'b0, xType = 1'b0, yValid = 1'b0, yType = 1'b0;
  logic [PW-1:0] xPrio = '0, yPrio = '0;
  logic [DW-1:0] xData = '0, yData = '0;
  logic          aValid, bValid, aFull, bFull, aDrop, bDrop;
  logic [PW-1:0] aPrio, bPrio;
  logic [DW-1:0] aData, bData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  psort_node #(.PRIO_W(PW), .DATA_W(DW)) u0 (.*);

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic drive(input logic stb, input logic xv, input logic xt, input int xp, input int xd,
                       input logic yv, input logic yt, input int yp, input int yd);
    slotStb = stb;
    xValid = xv; xType = xt; xPrio = PW'(xp); xData = DW'(xd);
    yValid = yv; yType = yt; yPrio = PW'(yp); yData = DW'(yd);
  endtask

  // one slot with only type-A traffic, then check port A after the edge
  task automatic slotA(input string tag, input logic xv, input int xp, input int xd,
                       input logic yv, input int yp, input int yd,
                       input logic ev, input int ep, input int ed);
    drive(1, xv, 0, xp, xd, yv, 0, yp, yd);
    @(negedge clk);
    chk({tag, " aValid"}, int'(aValid), int'(ev));
    if (ev) begin
      chk({tag, " aPrio"}, int'(aPrio), ep);
      chk({tag, " aData"}, int'(aData), ed);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset aValid", int'(aValid), 0);
    chk("R8 reset bValid", int'(bValid), 0);
    chk("R8 reset aFull", int'(aFull), 0);
    chk("R8 reset aDrop", int'(aDrop), 0);
    rst = 1'b0;

    // table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      drive(1, VEC[i].xv, VEC[i].xt, int'(VEC[i].xp), int'(VEC[i].xd),
               VEC[i].yv, VEC[i].yt, int'(VEC[i].yp), int'(VEC[i].yd));
      @(negedge clk);
      chk($sformatf("R2 R3 R4 R7 vec %0d aValid", i), int'(aValid), int'(VEC[i].av));
      chk($sformatf("R2 R7 vec %0d bValid", i), int'(bValid), int'(VEC[i].bv));
      if (VEC[i].av) begin
        chk($sformatf("R3 R4 vec %0d aPrio", i), int'(aPrio), int'(VEC[i].ap));
        chk($sformatf("R3 R4 vec %0d aData", i), int'(aData), int'(VEC[i].ad));
      end
      if (VEC[i].bv) begin
        chk($sformatf("R2 R3 vec %0d bPrio", i), int'(bPrio), int'(VEC[i].bp));
        chk($sformatf("R2 R3 vec %0d bData", i), int'(bData), int'(VEC[i].bd));
      end
      chk($sformatf("R5 vec %0d aFull", i), int'(aFull), int'(VEC[i].af));
      chk($sformatf("R6 vec %0d aDrop", i), int'(aDrop), int'(VEC[i].da));
      chk($sformatf("R6 vec %0d bDrop", i), int'(bDrop), int'(VEC[i].db));
    end

    // R1: inputs without strobe are ignored
    drive(0, 1, 0, 7, 8'h20, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R1 no strobe aValid", int'(aValid), 0);
    slotA("R1 idle slot after ignored input", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R9: result appears only after the edge and holds between slots
    drive(1, 1, 0, 7, 8'h21, 0, 0, 0, 0);
    #1;
    chk("R9 before edge aValid", int'(aValid), 0);
    @(negedge clk);
    chk("R9 after edge aValid", int'(aValid), 1);
    chk("R9 after edge aData", int'(aData), 8'h21);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R9 hold aValid", int'(aValid), 1);
    chk("R9 hold aData", int'(aData), 8'h21);

    // R5 R6: fill, overflow on X arrival, check pulse width, drain in order
    slotA("R5 fill1", 1, 1, 8'h30, 1, 2, 8'h31, 1, 2, 8'h31);
    slotA("R5 fill2", 1, 3, 8'h32, 1, 4, 8'h33, 1, 4, 8'h33);
    slotA("R5 fill3", 1, 5, 8'h34, 1, 6, 8'h35, 1, 6, 8'h35);
    slotA("R5 fill4", 1, 7, 8'h36, 1, 8, 8'h37, 1, 8, 8'h37);
    chk("R5 full after fill", int'(aFull), 1);
    slotA("R6 overflow", 1, 0, 8'h38, 1, 9, 8'h39, 1, 9, 8'h39);
    chk("R6 drop pulse", int'(aDrop), 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R6 drop one cycle", int'(aDrop), 0);
    chk("R5 still full", int'(aFull), 1);
    slotA("R6 drain1", 0, 0, 0, 0, 0, 0, 1, 7, 8'h36);
    chk("R5 full clears", int'(aFull), 0);
    slotA("R6 drain2", 0, 0, 0, 0, 0, 0, 1, 5, 8'h34);
    slotA("R6 drain3", 0, 0, 0, 0, 0, 0, 1, 3, 8'h32);
    slotA("R6 drain4", 0, 0, 0, 0, 0, 0, 1, 1, 8'h30);
    slotA("R6 dropped not kept", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R8: reset mid-run empties the type-B store
    drive(1, 1, 1, 3, 8'h40, 1, 1, 4, 8'h41);
    @(negedge clk);
    chk("R8 pre-reset bData", int'(bData), 8'h41);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 reset bValid", int'(bValid), 0);
    chk("R8 reset bFull", int'(bFull), 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 store emptied bValid", int'(bValid), 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule